// File: doc/BRIEF.md
# Multi-buffer frame address generator

This block produces memory write addresses for video fields that are stored in a ring of equally spaced buffers. Each buffer begins at a base address plus a whole number of inter-buffer steps. Each line inside a buffer begins at the buffer start plus a whole number of inter-line steps. A pixel strobe is turned into a write-enable only when the pixel falls inside the expected field size. Any excess pixels or lines are cropped. A field that is smaller than expected simply writes fewer locations.

Settings arrive from a register block and are marked valid by a one-cycle commit pulse. Committed settings are adopted at the next start of field, and adopting them always restarts the ring at the base address. In free-running mode the ring wraps back to the base. In single-shot mode it stops after the last buffer and waits for an acknowledge before another sequence can begin. When overwrite-broken is enabled, a damaged field keeps its buffer, so the next field writes into the same place.

Top module: `frame_addr_gen`

## Requirements
- R1: After a commit, the first accepted field starts at `cfg_base`. Every later field that completes normally starts at the previous start plus the active inter-buffer offset. `buf_addr` holds the start of the current field for as long as `busy` is high.
- R2: When a field starts, `line_addr` equals `buf_addr`. After each end-of-line inside a field that does not also end the field, `line_addr` advances by the active inter-line offset.
- R3: In free-running mode (`cfg_run`=1, `cfg_single`=0), once the field that fills the last of the N buffers completes, the next field starts at the active base again.
- R4: In single-shot mode (`cfg_run`=1, `cfg_single`=1), completing the N-th buffer raises `shot_done`. While `shot_done` is high, start-of-field is ignored: `busy` stays low and `wr_en` stays low.
- R5: A pulse on `avail_ack` clears `shot_done`. The next start-of-field then writes again, starting at the base address.
- R6: Committed settings take effect only at the next start-of-field. If a commit clears run during a field, that field still completes with all of its writes, and the following start-of-field is ignored.
- R7: Pixels and lines are counted from 0. `wr_en` is high only in a cycle where `busy` and `pix_valid` are both high, the pixel index within the line is below the active width, and the line index is below the active height.
- R8: A field that is narrower or shorter than expected produces exactly as many writes as the pixels it delivers. It still advances the ring in the usual way.
- R9: With `cfg_ovr_broken`=1, a field is treated as broken if `eof_broken` is set at end-of-field, or if its line count differs from the active height. A broken field does not advance the ring, so the next field starts at the same address.
- R10: A buffer count of 0 behaves like 1, so every field starts at the base address.
- R11: After reset, `busy`, `wr_en` and `shot_done` are 0, and both `line_addr` and `buf_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | AW | Base address of buffer 0 |
| cfg_nbuf | input | NBW | Number of buffers in the ring (0 is taken as 1) |
| cfg_buf_ofs | input | AW | Address step between buffers |
| cfg_line_ofs | input | AW | Address step between lines |
| cfg_run | input | 1 | 1 = write fields |
| cfg_single | input | 1 | 1 = stop after one pass through the ring |
| cfg_width | input | DW | Expected field width in pixels |
| cfg_height | input | DW | Expected field height in lines |
| cfg_commit | input | 1 | Pulse: the cfg_* values are new and apply from the next start of field |
| cfg_ovr_broken | input | 1 | Reuse the buffer of a broken field |
| avail_ack | input | 1 | Pulse: acknowledge that the single-shot pass is complete |
| sof | input | 1 | Start-of-field event |
| eol | input | 1 | End-of-line event |
| eof | input | 1 | End-of-field event |
| eof_broken | input | 1 | Marks the field ending with this eof as broken |
| pix_valid | input | 1 | A pixel is present this cycle |
| wr_en | output | 1 | Write this pixel |
| line_addr | output | AW | Start address of the current line |
| buf_addr | output | AW | Start address of the current buffer |
| busy | output | 1 | A field is being written |
| shot_done | output | 1 | The single-shot pass has completed |

## Verification
The hardest state to reach is the point where several effects coincide: single-shot mode has used its last buffer, the ring index no longer matches what a plain count of fields would give because broken fields held their buffer, and a commit arrived during a field. The stimulus gets there with a random walk over configurations. Buffer counts, modes and overwrite-broken settings are redrawn at random commits, and field sizes are drawn both above and below the expected size. Acknowledges are issued at random, so single-shot passes end, stall and restart in many different orders.

// File: rtl/fag_pkg.sv
package fag_pkg;
  // Effective ring length: a programmed count of zero behaves as one buffer.
  function automatic logic [15:0] ring_len(input logic [15:0] n);
    return (n == 16'd0) ? 16'd1 : n;
  endfunction
endpackage

// File: rtl/fag_cfg_shadow.sv
module fag_cfg_shadow #(
  parameter int AW  = 32,
  parameter int DW  = 12,
  parameter int NBW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit,
  input  logic           ld,
  input  logic [AW-1:0]  cfg_base,
  input  logic [NBW-1:0] cfg_nbuf,
  input  logic [AW-1:0]  cfg_buf_ofs,
  input  logic [AW-1:0]  cfg_line_ofs,
  input  logic           cfg_run,
  input  logic           cfg_single,
  input  logic [DW-1:0]  cfg_width,
  input  logic [DW-1:0]  cfg_height,
  output logic           pend,
  output logic [AW-1:0]  act_base,
  output logic [NBW-1:0] act_nbuf,
  output logic [AW-1:0]  act_bofs,
  output logic [AW-1:0]  act_lofs,
  output logic           act_run,
  output logic           act_single,
  output logic [DW-1:0]  act_w,
  output logic [DW-1:0]  act_h
);
  logic pend_n;

  always_comb begin
    pend_n = pend;
    if (ld)          pend_n = 1'b0;
    else if (commit) pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_base   <= '0;
      act_nbuf   <= '0;
      act_bofs   <= '0;
      act_lofs   <= '0;
      act_run    <= 1'b0;
      act_single <= 1'b0;
      act_w      <= '0;
      act_h      <= '0;
    end else if (ld) begin
      act_base   <= cfg_base;
      act_nbuf   <= cfg_nbuf;
      act_bofs   <= cfg_buf_ofs;
      act_lofs   <= cfg_line_ofs;
      act_run    <= cfg_run;
      act_single <= cfg_single;
      act_w      <= cfg_width;
      act_h      <= cfg_height;
    end
  end
endmodule

// File: rtl/fag_field_ctr.sv
module fag_field_ctr #(
  parameter int AW = 32,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          eol,
  input  logic          eof,
  input  logic          pix_valid,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] lofs,
  input  logic [DW-1:0] width,
  input  logic [DW-1:0] height,
  output logic          busy,
  output logic          wr_en,
  output logic [AW-1:0] line_addr,
  output logic [DW:0]   lines_rx
);
  localparam logic [DW-1:0] CNT_MAX = {DW{1'b1}};

  logic [DW-1:0] pix, line;
  logic [DW-1:0] pix_n, line_n;
  logic [AW-1:0] laddr_n;
  logic          busy_n;

  assign wr_en    = busy & pix_valid & (pix < width) & (line < height);
  assign lines_rx = {1'b0, line} + {{DW{1'b0}}, eol};

  always_comb begin
    busy_n  = busy;
    pix_n   = pix;
    line_n  = line;
    laddr_n = line_addr;
    if (go) begin
      busy_n  = 1'b1;
      pix_n   = '0;
      line_n  = '0;
      laddr_n = start_addr;
    end else if (busy) begin
      if (eol) begin
        pix_n   = '0;
        if (line != CNT_MAX) line_n = line + 1'b1;
        laddr_n = line_addr + lofs;
      end else if (pix_valid && pix != CNT_MAX) begin
        pix_n = pix + 1'b1;
      end
      if (eof) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pix       <= '0;
      line      <= '0;
      line_addr <= '0;
    end else begin
      busy      <= busy_n;
      pix       <= pix_n;
      line      <= line_n;
      line_addr <= laddr_n;
    end
  end
endmodule

// File: rtl/fag_buf_ring.sv
module fag_buf_ring #(
  parameter int AW  = 32,
  parameter int NBW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld,
  input  logic           go,
  input  logic           fin,
  input  logic           hold,
  input  logic           ack,
  input  logic [AW-1:0]  cfg_base,
  input  logic [AW-1:0]  act_base,
  input  logic [AW-1:0]  act_bofs,
  input  logic [NBW-1:0] act_nbuf,
  input  logic           act_single,
  output logic [AW-1:0]  start_addr,
  output logic [AW-1:0]  buf_addr,
  output logic           shot_done
);
  logic [NBW-1:0] idx, idx_n;
  logic [AW-1:0]  nxt, nxt_n, buf_n;
  logic           done_n;
  logic [NBW:0]   nbe;

  always_comb begin
    nbe = (act_nbuf == '0) ? {{NBW{1'b0}}, 1'b1} : {1'b0, act_nbuf};
  end

  assign start_addr = ld ? cfg_base : nxt;

  always_comb begin
    idx_n  = idx;
    nxt_n  = nxt;
    buf_n  = buf_addr;
    done_n = shot_done;
    if (ack) done_n = 1'b0;
    if (ld) begin
      idx_n  = '0;
      nxt_n  = cfg_base;
      done_n = 1'b0;
    end
    if (go) buf_n = start_addr;
    if (fin && !hold) begin
      if (({1'b0, idx} + 1'b1) >= nbe) begin
        idx_n = '0;
        nxt_n = act_base;
        if (act_single) done_n = 1'b1;
      end else begin
        idx_n = idx + 1'b1;
        nxt_n = buf_addr + act_bofs;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      nxt       <= '0;
      buf_addr  <= '0;
      shot_done <= 1'b0;
    end else begin
      idx       <= idx_n;
      nxt       <= nxt_n;
      buf_addr  <= buf_n;
      shot_done <= done_n;
    end
  end
endmodule

// File: rtl/frame_addr_gen.sv
module frame_addr_gen #(
  parameter int AW  = 32,
  parameter int DW  = 12,
  parameter int NBW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  cfg_base,
  input  logic [NBW-1:0] cfg_nbuf,
  input  logic [AW-1:0]  cfg_buf_ofs,
  input  logic [AW-1:0]  cfg_line_ofs,
  input  logic           cfg_run,
  input  logic           cfg_single,
  input  logic [DW-1:0]  cfg_width,
  input  logic [DW-1:0]  cfg_height,
  input  logic           cfg_commit,
  input  logic           cfg_ovr_broken,
  input  logic           avail_ack,
  input  logic           sof,
  input  logic           eol,
  input  logic           eof,
  input  logic           eof_broken,
  input  logic           pix_valid,
  output logic           wr_en,
  output logic [AW-1:0]  line_addr,
  output logic [AW-1:0]  buf_addr,
  output logic           busy,
  output logic           shot_done
);
  logic           pend, ld, go, fin, hold;
  logic           run_e, sgl_e, done_e;
  logic [AW-1:0]  act_base, act_bofs, act_lofs, start_addr;
  logic [NBW-1:0] act_nbuf;
  logic           act_run, act_single;
  logic [DW-1:0]  act_w, act_h;
  logic [DW:0]    lines_rx;

  always_comb begin
    ld     = sof & ~busy & (pend | cfg_commit);
    run_e  = ld ? cfg_run    : act_run;
    sgl_e  = ld ? cfg_single : act_single;
    done_e = ld ? 1'b0       : shot_done;
    go     = sof & ~busy & run_e & ~(sgl_e & done_e);
    fin    = busy & eof;
    hold   = cfg_ovr_broken & (eof_broken | (lines_rx != {1'b0, act_h}));
  end

  fag_cfg_shadow #(.AW(AW), .DW(DW), .NBW(NBW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .commit(cfg_commit), .ld(ld),
    .cfg_base(cfg_base), .cfg_nbuf(cfg_nbuf), .cfg_buf_ofs(cfg_buf_ofs),
    .cfg_line_ofs(cfg_line_ofs), .cfg_run(cfg_run), .cfg_single(cfg_single),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .pend(pend),
    .act_base(act_base), .act_nbuf(act_nbuf), .act_bofs(act_bofs),
    .act_lofs(act_lofs), .act_run(act_run), .act_single(act_single),
    .act_w(act_w), .act_h(act_h)
  );

  fag_field_ctr #(.AW(AW), .DW(DW)) u_field (
    .clk(clk), .rst_n(rst_n), .go(go), .eol(eol), .eof(eof),
    .pix_valid(pix_valid), .start_addr(start_addr), .lofs(act_lofs),
    .width(act_w), .height(act_h), .busy(busy), .wr_en(wr_en),
    .line_addr(line_addr), .lines_rx(lines_rx)
  );

  fag_buf_ring #(.AW(AW), .NBW(NBW)) u_ring (
    .clk(clk), .rst_n(rst_n), .ld(ld), .go(go), .fin(fin), .hold(hold),
    .ack(avail_ack), .cfg_base(cfg_base), .act_base(act_base),
    .act_bofs(act_bofs), .act_nbuf(act_nbuf), .act_single(act_single),
    .start_addr(start_addr), .buf_addr(buf_addr), .shot_done(shot_done)
  );
endmodule

// File: rtl/fag_chk.sv
module fag_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          wr_en,
  input logic          eol,
  input logic          eof,
  input logic          shot_done,
  input logic [AW-1:0] line_addr,
  input logic [AW-1:0] buf_addr,
  input logic [AW-1:0] lofs
);
  // R7
  no_wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);
  // R1
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(buf_addr));
  // R2
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> line_addr == buf_addr);
  // R2
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy && eol && !eof) |-> line_addr == $past(line_addr) + $past(lofs));
  // R4
  shot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shot_done) |-> !busy);
endmodule

bind frame_addr_gen fag_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wr_en(wr_en), .eol(eol),
  .eof(eof), .shot_done(shot_done), .line_addr(line_addr),
  .buf_addr(buf_addr), .lofs(act_lofs)
);

// File: tb/sim_frame_addr_gen.sv
`timescale 1ns/1ps
module sim_frame_addr_gen;
  localparam int AW = 32, DW = 12, NBW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] cfg_base = '0, cfg_buf_ofs = '0, cfg_line_ofs = '0;
  logic [NBW-1:0] cfg_nbuf = '0;
  logic cfg_run = 0, cfg_single = 0, cfg_commit = 0, cfg_ovr_broken = 0;
  logic [DW-1:0] cfg_width = '0, cfg_height = '0;
  logic avail_ack = 0, sof = 0, eol = 0, eof = 0, eof_broken = 0, pix_valid = 0;
  logic wr_en, busy, shot_done;
  logic [AW-1:0] line_addr, buf_addr;

  always #2 clk = ~clk;

  frame_addr_gen #(.AW(AW), .DW(DW), .NBW(NBW)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  // reference state
  int m_idx = 0; bit m_done = 0, m_pend = 0;
  logic [AW-1:0] a_base = 0, a_bofs = 0, a_lofs = 0;
  int a_nbuf = 0, a_w = 0, a_h = 0; bit a_run = 0, a_single = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic do_commit();
    @(negedge clk) cfg_commit = 1;
    @(negedge clk) cfg_commit = 0;
    m_pend = 1;
  endtask

  task automatic do_ack();
    @(negedge clk) avail_ack = 1;
    @(negedge clk) avail_ack = 0;
    m_done = 0;
    chk(shot_done == 1'b0, "R5 ack clears shot_done", shot_done, 0);
  endtask

  task automatic field(input int rw, input int rh, input bit brk, input bit kill);
    bit go, hold; logic [AW-1:0] st; int wr, expw, nbe;
    if (m_pend) begin
      a_base = cfg_base; a_nbuf = cfg_nbuf; a_bofs = cfg_buf_ofs; a_lofs = cfg_line_ofs;
      a_run = cfg_run; a_single = cfg_single; a_w = cfg_width; a_h = cfg_height;
      m_idx = 0; m_done = 0; m_pend = 0;
    end
    go = a_run && !(a_single && m_done);
    st = a_base + AW'(m_idx) * a_bofs;
    @(negedge clk) sof = 1;
    @(negedge clk) sof = 0;
    chk(busy == go, "R4/R6 field accepted", busy, go);
    if (go) chk(buf_addr == st, "R1/R3/R9/R10 buffer start", buf_addr, st);
    wr = 0;
    for (int l = 0; l < rh; l++) begin
      if (go) chk(line_addr == st + AW'(l) * a_lofs, "R2 line start", line_addr, st + AW'(l) * a_lofs);
      for (int p = 0; p < rw; p++) begin
        pix_valid = 1;
        #1 if (wr_en) wr++;
        @(negedge clk);
      end
      pix_valid = 0; eol = 1; eof = (l == rh - 1); eof_broken = brk && (l == rh - 1);
      if (kill && l == 0) begin cfg_run = 0; cfg_commit = 1; m_pend = 1; end
      @(negedge clk);
      eol = 0; eof = 0; eof_broken = 0; cfg_commit = 0;
    end
    expw = go ? mn(rw, a_w) * mn(rh, a_h) : 0;
    chk(wr == expw, "R7/R8 write count", wr, expw);
    chk(busy == 1'b0, "R6 field ended", busy, 0);
    if (go) begin
      hold = cfg_ovr_broken && (brk || rh != a_h);
      nbe = (a_nbuf == 0) ? 1 : a_nbuf;
      if (!hold) begin
        m_idx++;
        if (m_idx >= nbe) begin m_idx = 0; if (a_single) m_done = 1; end
      end
    end
    chk(shot_done == m_done, "R4 shot_done", shot_done, m_done);
  endtask

  task automatic setcfg(input int base, input int nb, input int bo, input int lo,
                        input bit run, input bit sgl, input int w, input int h);
    cfg_base = AW'(base); cfg_nbuf = NBW'(nb); cfg_buf_ofs = AW'(bo); cfg_line_ofs = AW'(lo);
    cfg_run = run; cfg_single = sgl; cfg_width = DW'(w); cfg_height = DW'(h);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy == 0 && wr_en == 0 && shot_done == 0, "R11 reset flags", {busy, wr_en, shot_done}, 0);
    chk(line_addr == 0 && buf_addr == 0, "R11 reset addresses", line_addr | buf_addr, 0);
    rst_n = 1;
    // R1, R3: free-running wrap over three buffers
    setcfg(32'h1000, 3, 32'h400, 32'h40, 1, 0, 8, 4);
    do_commit();
    repeat (4) field(8, 4, 0, 0);
    // R7 oversized field cropped, R8 short field
    field(11, 6, 0, 0);
    field(5, 2, 0, 0);
    // R9 overwrite-broken holds the buffer
    cfg_ovr_broken = 1;
    field(8, 4, 1, 0);
    field(8, 3, 0, 0);
    field(8, 4, 0, 0);
    cfg_ovr_broken = 0;
    // R4, R5 single shot
    setcfg(32'h8000, 2, 32'h200, 32'h20, 1, 1, 4, 2);
    do_commit();
    repeat (3) field(4, 2, 0, 0);
    do_ack();
    field(4, 2, 0, 0);
    // R10 count of zero
    setcfg(32'h2000, 0, 32'h100, 32'h10, 1, 0, 3, 2);
    do_commit();
    repeat (2) field(3, 2, 0, 0);
    // R6 run cleared mid-field
    setcfg(32'h3000, 3, 32'h100, 32'h10, 1, 0, 3, 2);
    do_commit();
    field(3, 2, 0, 1);
    field(3, 2, 0, 0);
    // random walk
    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        setcfg($urandom_range(0, 255) * 16, $urandom_range(0, 4), $urandom_range(1, 64) * 64,
               $urandom_range(1, 8) * 4, $urandom_range(0, 5) != 0, $urandom_range(0, 1),
               $urandom_range(1, 10), $urandom_range(1, 5));
        do_commit();
      end
      cfg_ovr_broken = ($urandom_range(0, 2) == 0);
      if (m_done && $urandom_range(0, 1)) do_ack();
      field($urandom_range(1, 12), $urandom_range(1, 6), $urandom_range(0, 3) == 0, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule